// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Multiprocessor Wakeup

This block receives characters from a single asynchronous NRZ serial line and queues them for a host. A programmable 16-bit divisor sets the oversampling rate. Each bit period is split into sixteen sample ticks. Every bit value is settled by a majority vote taken near the middle of the bit. Data length (1 to 8 bits), parity (none, even or odd) and the number of stop bits (one or two) can all be changed at runtime between frames. Received characters go into a 16-entry first-in-first-out queue. The host drains it through a show-ahead read port.

The receiver watches every frame for four problems: bad parity, a bad stop bit, a frame arriving while the queue is full, and a line held low for the whole frame. Each problem sets its own sticky flag. An OR of the four flags is given as a combined error output. The interrupt output combines the ready and error conditions under an enable, but a line break raises it regardless of that enable.

For bus-style networks with several listeners, the receiver can be put to sleep. While asleep it throws away every frame that is not marked as an address frame. In the address-bit scheme, an extra bit sent after the data marks the address. In the idle-line scheme, a long quiet gap before the start bit marks the address. An address frame wakes the receiver and is stored.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is a low start bit, then `data_len`+1 data bits least significant first, then an address bit only when `wake_mode` is 2'b10, then a parity bit only when parity is enabled, then one stop bit (`two_stop`=0) or two (`two_stop`=1). A frame with good parity and high stop bits is stored with no flag raised.
- R2: `parity_mode` 2'b01 selects even parity and 2'b10 selects odd parity, counted over the data bits, the address bit (when present) and the parity bit. 2'b00 and 2'b11 mean no parity bit. A mismatch sets `flag_parity`, and the character is still stored.
- R3: The queue holds up to 16 characters in arrival order. `rd_data` shows the oldest one. `rx_ready` is high while the queue is not empty. `fifo_count` gives the fill level. A cycle with `rd_en` high and `rx_ready` high removes one entry.
- R4: All four flags stay set until a cycle with `clr_flags` high, which clears them. `rx_error` is high whenever any of the four flags is set.
- R5: One sample tick occurs every `baud_div`+1 clock cycles, and one bit lasts 16 ticks.
- R6: Each bit value is the majority of the samples taken at ticks 7, 8 and 9 of the bit. A falling edge whose start bit votes high is a glitch: it is ignored and leaves no entry and no flag.
- R7: A character shorter than 8 bits sits in bits [n-1:0] of its entry. All higher bits read as zero.
- R8: A stop bit that votes low, in a frame that is not a break, sets `flag_frame`. The character is still stored.
- R9: A character that completes while the queue holds 16 entries is dropped and sets `flag_overrun`. The entries already in the queue are kept.
- R10: A frame in which every sampled bit, stop bits included, is low is a break. It sets `flag_break` and writes no entry. The receiver then waits for the line to return high before it looks for a new start bit.
- R11: With `wake_mode` 2'b10, a receiver that is asleep discards frames whose address bit is 0. A frame whose address bit is 1 is stored and wakes the receiver (`awake` high). While awake, every frame is stored. A `sleep_req` pulse puts the receiver back to sleep, and it is asleep after reset.
- R12: With `wake_mode` 2'b01, a frame is an address frame when the line has been idle high for at least 10 bit times (160 ticks) before its start bit. Sleep, discard and wake then behave as in R11.
- R13: `rx_irq` is high when `rx_ie` is high and either `rx_ready`, `flag_parity`, `flag_frame` or `flag_overrun` is high. It is also high whenever `flag_break` is set, whatever the value of `rx_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_div | input | 16 | Sample tick divisor; tick period is baud_div+1 clocks |
| data_len | input | 3 | Number of data bits minus one |
| parity_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| two_stop | input | 1 | 1 selects two stop bits |
| wake_mode | input | 2 | 00 off, 01 idle-line, 10 address-bit, 11 off |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rd_en | input | 1 | Removes the oldest queue entry |
| clr_flags | input | 1 | Clears all four error flags |
| rx_ie | input | 1 | Enables the ready and non-break error interrupts |
| rd_data | output | 8 | Oldest queued character |
| rx_ready | output | 1 | Queue not empty |
| fifo_count | output | 5 | Number of queued characters |
| flag_parity | output | 1 | Sticky parity error |
| flag_frame | output | 1 | Sticky framing error |
| flag_overrun | output | 1 | Sticky overrun error |
| flag_break | output | 1 | Sticky break detected |
| rx_error | output | 1 | OR of the four flags |
| rx_irq | output | 1 | Receive interrupt |
| awake | output | 1 | Receiver accepts every frame |

## Verification
The hardest situation to produce from the ports is the idle-line address decision. It depends on how long the line has been quiet, counted in ticks from partway through the previous stop bit. The bench gets there by sending one frame right after another, with a gap well under 10 bit times, and then a further frame after a gap of 14 bit times. Only the last of these may be accepted. Overrun is the other hard case: the bench must push 17 complete frames without a single read. The first sixteen values are then read back to show that nothing already queued was lost.

// File: rtl/serial_rx_pkg.sv
// Shared constants and the decoder state type for the serial receiver.
// Assumes a fixed 16x oversampling with the vote taken on ticks 7, 8 and 9.
package serial_rx_pkg;

    localparam int OVERSAMPLE  = 16;
    localparam int VOTE_FIRST  = 7;
    localparam int IDLE_BITS   = 10;
    localparam int IDLE_TICKS  = IDLE_BITS * OVERSAMPLE;

    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ODD   = 2'b10;
    localparam logic [1:0] WAKE_IDLE = 2'b01;
    localparam logic [1:0] WAKE_ADDR = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_HOLD
    } rx_state_e;

endpackage

// File: rtl/rx_tick_sync.sv
// Brings the asynchronous line into the clock domain and produces the
// oversampling tick. Assumes the divisor only changes while the line is idle.
module rx_tick_sync #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_async,
    input  logic [DIV_W-1:0] div,
    output logic             line_s,
    output logic             tick
);

    logic             meta_q;
    logic             sync_q;
    logic [DIV_W-1:0] div_cnt;

    // two-flop synchronizer, reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
        end
    end

    // divisor counter: one tick each div+1 clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt >= div) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end

    assign line_s = sync_q;

endmodule

// File: rtl/rx_frame_decoder.sv
// Walks one serial frame tick by tick: start validation, data, optional
// address and parity bits, and stop bits. Reports each finished frame with
// a one-cycle pulse. Also measures the idle time that comes before each start bit.
// Assumes the format inputs are held steady while a frame is in progress.
module rx_frame_decoder
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [2:0]        data_len,
    input  logic [1:0]        parity_mode,
    input  logic              two_stop,
    input  logic              addr_bit_en,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              addr_bit,
    output logic              idle_addr,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk
);

    localparam int ICW = $clog2(IDLE_TICKS + 1);
    localparam logic [ICW-1:0] IDLE_LIM = ICW'(IDLE_TICKS);
    localparam logic [3:0] T_V0   = 4'(VOTE_FIRST);
    localparam logic [3:0] T_V1   = 4'(VOTE_FIRST + 1);
    localparam logic [3:0] T_DEC  = 4'(VOTE_FIRST + 2);
    localparam logic [3:0] T_LAST = 4'(OVERSAMPLE - 1);

    rx_state_e         state;
    logic [3:0]        tcnt;
    logic [2:0]        bidx;
    logic              v7, v8;
    logic              par_acc, any_one, stop_bad;
    logic [ICW-1:0]    idle_cnt;
    logic              bit_v;
    logic              par_on, last_stop;
    rx_state_e         after_data;

    // majority of the three mid-bit samples
    assign bit_v = (v7 & v8) | (v7 & line) | (v8 & line);

    // format decode for the field sequence
    always_comb begin
        par_on    = (parity_mode == PAR_EVEN) || (parity_mode == PAR_ODD);
        last_stop = (state == ST_STOP2) || (state == ST_STOP1 && !two_stop);
        if (addr_bit_en)  after_data = ST_ADDR;
        else if (par_on)  after_data = ST_PAR;
        else              after_data = ST_STOP1;
    end

    // frame state machine advanced on sample ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            v7        <= 1'b1;
            v8        <= 1'b1;
            par_acc   <= 1'b0;
            any_one   <= 1'b0;
            stop_bad  <= 1'b0;
            idle_cnt  <= '0;
            done      <= 1'b0;
            data      <= '0;
            addr_bit  <= 1'b0;
            idle_addr <= 1'b0;
            par_err   <= 1'b0;
            frm_err   <= 1'b0;
            brk       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state     <= ST_START;
                            tcnt      <= 4'd1;
                            bidx      <= '0;
                            data      <= '0;
                            addr_bit  <= 1'b0;
                            par_acc   <= 1'b0;
                            any_one   <= 1'b0;
                            stop_bad  <= 1'b0;
                            idle_addr <= (idle_cnt >= IDLE_LIM);
                            idle_cnt  <= '0;
                        end else if (idle_cnt < IDLE_LIM) begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == T_V0) v7 <= line;
                        if (tcnt == T_V1) v8 <= line;
                        if (tcnt == T_DEC) begin
                            unique case (state)
                                ST_START: if (bit_v) state <= ST_IDLE;
                                ST_DATA: begin
                                    data[bidx] <= bit_v;
                                    par_acc    <= par_acc ^ bit_v;
                                    any_one    <= any_one | bit_v;
                                end
                                ST_ADDR: begin
                                    addr_bit <= bit_v;
                                    par_acc  <= par_acc ^ bit_v;
                                    any_one  <= any_one | bit_v;
                                end
                                ST_PAR: begin
                                    par_acc <= par_acc ^ bit_v;
                                    any_one <= any_one | bit_v;
                                end
                                default: begin
                                    any_one  <= any_one | bit_v;
                                    stop_bad <= stop_bad | !bit_v;
                                    if (last_stop) begin
                                        done    <= 1'b1;
                                        brk     <= !(any_one | bit_v);
                                        frm_err <= (stop_bad | !bit_v) & (any_one | bit_v);
                                        par_err <= par_on & (par_acc ^ (parity_mode == PAR_ODD));
                                        state   <= (any_one | bit_v) ? ST_IDLE : ST_HOLD;
                                    end
                                end
                            endcase
                        end
                        if (tcnt == T_LAST) begin
                            unique case (state)
                                ST_START: state <= ST_DATA;
                                ST_DATA: begin
                                    if (bidx == data_len) state <= after_data;
                                    else                  bidx  <= bidx + 1'b1;
                                end
                                ST_ADDR:  state <= par_on ? ST_PAR : ST_STOP1;
                                ST_PAR:   state <= ST_STOP1;
                                default:  state <= ST_STOP2;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // R1: a frame takes many ticks, so two completions never abut
    p_done_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a start bit that votes high returns the decoder to idle
    p_glitch_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_START && tcnt == T_DEC && bit_v) |=> (state == ST_IDLE && !done));

endmodule

// File: rtl/rx_wake_gate.sv
// Decides, for each finished frame, whether it reaches the queue under the
// selected multiprocessor wakeup scheme. Holds the sleep state.
// Assumes done is a single-cycle pulse.
module rx_wake_gate
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  logic       brk,
    input  logic       addr_bit,
    input  logic       idle_addr,
    input  logic [1:0] wake_mode,
    input  logic       sleep_req,
    output logic       store,
    output logic       awake
);

    logic sleeping;
    logic filter_on;
    logic is_addr;

    // classify the finished frame
    always_comb begin
        filter_on = (wake_mode == WAKE_IDLE) || (wake_mode == WAKE_ADDR);
        unique case (wake_mode)
            WAKE_ADDR: is_addr = addr_bit;
            WAKE_IDLE: is_addr = idle_addr;
            default:   is_addr = 1'b0;
        endcase
        store = done && !brk && (!filter_on || !sleeping || is_addr);
    end

    // sleep state: set by request, cleared by a received address frame
    always_ff @(posedge clk) begin
        if (!rst_n)                          sleeping <= 1'b1;
        else if (done && !brk && is_addr)    sleeping <= 1'b0;
        else if (sleep_req)                  sleeping <= 1'b1;
    end

    assign awake = !sleeping;

    // R11: a sleeping receiver under a wake scheme drops non-address frames
    p_sleep_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && filter_on && sleeping && !is_addr) |-> !store);

endmodule

// File: rtl/rx_char_fifo.sv
// Show-ahead first-in-first-out queue for received characters.
// Assumes callers gate pop with not-empty. A push while full is discarded here.
module rx_char_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rdata,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R3: a push into a full queue leaves its level unchanged
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R3: popping an empty queue never wraps the level
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/serial_rx_core.sv
// Top of the serial receiver: tick generation, frame decoding, wakeup
// filtering, character queue, sticky error flags and interrupt.
// Assumes format and wake settings change only while the line is idle.
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_line,
    input  logic [DIV_W-1:0]             baud_div,
    input  logic [2:0]                   data_len,
    input  logic [1:0]                   parity_mode,
    input  logic                         two_stop,
    input  logic [1:0]                   wake_mode,
    input  logic                         sleep_req,
    input  logic                         rd_en,
    input  logic                         clr_flags,
    input  logic                         rx_ie,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rx_ready,
    output logic [$clog2(FIFO_DEPTH):0]  fifo_count,
    output logic                         flag_parity,
    output logic                         flag_frame,
    output logic                         flag_overrun,
    output logic                         flag_break,
    output logic                         rx_error,
    output logic                         rx_irq,
    output logic                         awake
);

    logic              line_s, tick;
    logic              dec_done, dec_addr, dec_idle, dec_par, dec_frm, dec_brk;
    logic [DATA_W-1:0] dec_data;
    logic              store, fifo_full, fifo_empty;

    rx_tick_sync #(.DIV_W(DIV_W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (rx_line),
        .div        (baud_div),
        .line_s     (line_s),
        .tick       (tick)
    );

    rx_frame_decoder #(.DATA_W(DATA_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .line        (line_s),
        .data_len    (data_len),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .addr_bit_en (wake_mode == WAKE_ADDR),
        .done        (dec_done),
        .data        (dec_data),
        .addr_bit    (dec_addr),
        .idle_addr   (dec_idle),
        .par_err     (dec_par),
        .frm_err     (dec_frm),
        .brk         (dec_brk)
    );

    rx_wake_gate u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (dec_done),
        .brk       (dec_brk),
        .addr_bit  (dec_addr),
        .idle_addr (dec_idle),
        .wake_mode (wake_mode),
        .sleep_req (sleep_req),
        .store     (store),
        .awake     (awake)
    );

    rx_char_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (store),
        .wdata (dec_data),
        .pop   (rd_en && rx_ready),
        .rdata (rd_data),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    assign rx_ready = !fifo_empty;

    // sticky error flags: new events win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_parity  <= 1'b0;
            flag_frame   <= 1'b0;
            flag_overrun <= 1'b0;
            flag_break   <= 1'b0;
        end else begin
            flag_parity  <= (flag_parity  && !clr_flags) || (store && dec_par);
            flag_frame   <= (flag_frame   && !clr_flags) || (store && dec_frm);
            flag_overrun <= (flag_overrun && !clr_flags) || (store && fifo_full);
            flag_break   <= (flag_break   && !clr_flags) || (dec_done && dec_brk);
        end
    end

    assign rx_error = flag_parity | flag_frame | flag_overrun | flag_break;
    assign rx_irq   = (rx_ie & (rx_ready | flag_parity | flag_frame | flag_overrun))
                    | flag_break;

    // R9: overrun stays set until cleared
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_overrun && !clr_flags) |=> flag_overrun);

    // R10: a break never produces a queue write
    p_break_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_brk) |-> !store);

    // R13: break interrupt ignores the enable
    p_break_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        flag_break |-> rx_irq);

endmodule

// File: tb/serial_rx_core_test.sv
// Self-checking bench: sweeps all frame formats, then drives error, wakeup,
// overrun and divisor cases, with expected values computed here.
module serial_rx_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [15:0] baud_div = 16'd0;
    logic [2:0]  data_len = 3'd7;
    logic [1:0]  parity_mode = 2'b00;
    logic        two_stop = 1'b0;
    logic [1:0]  wake_mode = 2'b00;
    logic        sleep_req = 1'b0;
    logic        rd_en = 1'b0;
    logic        clr_flags = 1'b0;
    logic        rx_ie = 1'b0;
    logic [7:0]  rd_data;
    logic        rx_ready, flag_parity, flag_frame, flag_overrun, flag_break;
    logic        rx_error, rx_irq, awake;
    logic [4:0]  fifo_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_rx_core uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
        .data_len(data_len), .parity_mode(parity_mode), .two_stop(two_stop),
        .wake_mode(wake_mode), .sleep_req(sleep_req), .rd_en(rd_en),
        .clr_flags(clr_flags), .rx_ie(rx_ie), .rd_data(rd_data),
        .rx_ready(rx_ready), .fifo_count(fifo_count), .flag_parity(flag_parity),
        .flag_frame(flag_frame), .flag_overrun(flag_overrun),
        .flag_break(flag_break), .rx_error(rx_error), .rx_irq(rx_irq),
        .awake(awake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rx_line = 1'b1;
        repeat (n * 16 * (int'(baud_div) + 1)) @(negedge clk);
    endtask

    // drive one frame from the current settings
    task automatic send(input logic [7:0] d, input logic addr, input logic bad_par,
                        input logic bad_stop);
        int   n;
        logic ones;
        n    = int'(data_len) + 1;
        ones = addr & (wake_mode == 2'b10);
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            hold_bit(d[i]);
            ones ^= d[i];
        end
        if (wake_mode == 2'b10) hold_bit(addr);
        if (parity_mode == 2'b01) hold_bit(ones ^ bad_par);
        if (parity_mode == 2'b10) hold_bit(~ones ^ bad_par);
        hold_bit(~bad_stop);
        if (two_stop) hold_bit(~bad_stop);
        rx_line = 1'b1;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        chk({tag, " ready"}, int'(rx_ready), 1);
        chk({tag, " data"}, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] mask, v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R3 reset ready", int'(rx_ready), 0);
        chk("R3 reset count", int'(fifo_count), 0);
        chk("R4 reset error", int'(rx_error), 0);
        chk("R13 reset irq", int'(rx_irq), 0);
        chk("R11 reset asleep", int'(awake), 0);
        idle_bits(2);

        // R1 R2 R7 sweep of every format
        for (int len = 1; len <= 8; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    data_len    = 3'(len - 1);
                    parity_mode = 2'(pm);
                    two_stop    = 1'(ts);
                    mask        = 8'((1 << len) - 1);
                    for (int k = 0; k < 2; k++) begin
                        v = 8'hA5 ^ 8'(k * 8'h5E + len * 13 + pm * 7);
                        send(v, 1'b0, 1'b0, 1'b0);
                    end
                    idle_bits(1);
                    for (int k = 0; k < 2; k++) begin
                        v = 8'hA5 ^ 8'(k * 8'h5E + len * 13 + pm * 7);
                        pop_chk("R1 R7 sweep", v & mask);
                    end
                    chk("R2 sweep no error", int'(rx_error), 0);
                end
            end
        end

        // R2 R4 parity error, still stored
        data_len = 3'd7; parity_mode = 2'b01; two_stop = 1'b0;
        send(8'h6C, 1'b0, 1'b1, 1'b0);
        idle_bits(1);
        chk("R2 parity flag", int'(flag_parity), 1);
        chk("R4 combined", int'(rx_error), 1);
        pop_chk("R2 parity data", 8'h6C);
        idle_bits(1);
        chk("R4 sticky", int'(flag_parity), 1);
        pulse_clear();
        chk("R4 cleared", int'(rx_error), 0);

        // R8 framing error
        parity_mode = 2'b00;
        send(8'h81, 1'b0, 1'b0, 1'b1);
        idle_bits(2);
        chk("R8 frame flag", int'(flag_frame), 1);
        chk("R8 not break", int'(flag_break), 0);
        pop_chk("R8 frame data", 8'h81);
        pulse_clear();

        // R10 R13 break
        rx_ie = 1'b0;
        repeat (13) hold_bit(1'b0);
        idle_bits(2);
        chk("R10 break flag", int'(flag_break), 1);
        chk("R10 no entry", int'(fifo_count), 0);
        chk("R13 break irq unmasked", int'(rx_irq), 1);
        pulse_clear();
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        pop_chk("R10 after break", 8'h3C);

        // R6 start glitch
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        idle_bits(2);
        chk("R6 glitch no entry", int'(fifo_count), 0);
        chk("R6 glitch no flag", int'(rx_error), 0);
        send(8'h5A, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        pop_chk("R6 after glitch", 8'h5A);

        // R13 interrupt enable
        send(8'h77, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        chk("R13 masked", int'(rx_irq), 0);
        rx_ie = 1'b1;
        @(negedge clk);
        chk("R13 enabled", int'(rx_irq), 1);
        pop_chk("R13 data", 8'h77);
        chk("R13 empty irq", int'(rx_irq), 0);
        rx_ie = 1'b0;

        // R9 overrun
        for (int i = 0; i < 17; i++) send(8'(i * 9 + 1), 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        chk("R9 count full", int'(fifo_count), 16);
        chk("R9 overrun flag", int'(flag_overrun), 1);
        for (int i = 0; i < 16; i++) pop_chk("R9 R3 order", 8'(i * 9 + 1));
        chk("R3 drained", int'(fifo_count), 0);
        pulse_clear();

        // R11 address-bit wakeup
        wake_mode = 2'b10;
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        send(8'h11, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        chk("R11 discarded", int'(fifo_count), 0);
        chk("R11 still asleep", int'(awake), 0);
        send(8'h22, 1'b1, 1'b0, 1'b0);
        idle_bits(1);
        chk("R11 woke", int'(awake), 1);
        send(8'h33, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        pop_chk("R11 address", 8'h22);
        pop_chk("R11 data awake", 8'h33);

        // R12 idle-line wakeup
        wake_mode = 2'b01;
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        idle_bits(14);
        send(8'h44, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        chk("R12 long gap wakes", int'(awake), 1);
        pop_chk("R12 first", 8'h44);
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        send(8'h55, 1'b0, 1'b0, 1'b0);
        send(8'h56, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        chk("R12 short gap dropped", int'(fifo_count), 0);
        chk("R12 asleep", int'(awake), 0);
        idle_bits(13);
        send(8'h66, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        pop_chk("R12 second", 8'h66);
        wake_mode = 2'b00;

        // R5 slower divisor with odd parity and two stops
        baud_div = 16'd2; parity_mode = 2'b10; two_stop = 1'b1;
        idle_bits(1);
        send(8'hC3, 1'b0, 1'b0, 1'b0);
        idle_bits(1);
        pop_chk("R5 divisor", 8'hC3);
        chk("R5 no error", int'(rx_error), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule